// File: doc/BRIEF.md
# Dual-Port Address-Collision Busy Arbiter

This block watches two independent memory ports, left and right. Each port has its own active-low chip select, its own address and its own active-low write strobe. If both ports are selected and present the same address, the block gives the location to the port whose select and address settled first. It drives an active-low busy flag to the other port and blocks that port's write before the write reaches the storage array. The array, output-enable timing and analog setup measurement are not part of this block.

Arrival order is measured in clock cycles. Each port keeps a saturating age: the number of clock edges since its select and address last changed. Two arrivals that are closer than a configurable window are treated as simultaneous, and the left port wins a tie. In master mode the block drives both busy pins push-pull. In slave mode it drives neither pin, and each incoming busy level gates only that port's write.

Top module: `port_clash_arbiter`

## Requirements
- R1: When both ports are selected but their addresses differ, both `l_busy_n` and `r_busy_n` are 1.
- R2: When either `l_cs_n` or `r_cs_n` is 1, both busy outputs are 1, whatever the addresses are.
- R3: In master mode (`slave_mode`=0), with both ports selected at the same address and ages that differ by at least `WIN`, the port with the smaller age (the later arrival) sees its busy at 0 and the other port sees its busy at 1.
- R4: In master mode, under the same match, if the ages differ by less than `WIN` the right port is marked busy and the left port is not. The two busy outputs are never 0 together.
- R5: A port's age is 0 in any cycle where `{cs_n, addr}` differs from its value at the previous clock edge. Otherwise the age is the number of edges since the last change, held at 2^`AGE_W`−1 once it reaches that value. After reset both ages are saturated and the reference value is `{1, 0}`.
- R6: In master mode, `x_wr_n` equals `x_we_n` OR NOT `x_busy_n` for each port. The `x_busy_in_n` pins have no effect.
- R7: In slave mode (`slave_mode`=1), both busy outputs are 1, and `x_wr_n` equals `x_we_n` OR NOT `x_busy_in_n`.
- R8: `busy_drive` is 1 in master mode and 0 in slave mode.
- R9: Busy is decided combinationally in each cycle. It releases in the same cycle that the match or either select goes away.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slave_mode | input | 1 | 1 selects slave mode: busy pins act as inputs |
| l_cs_n | input | 1 | Left chip select, active low |
| l_addr | input | AW | Left address |
| l_we_n | input | 1 | Left write strobe from the port, active low |
| l_busy_in_n | input | 1 | Left busy level from the pin (used in slave mode) |
| l_busy_n | output | 1 | Left busy flag, active low, push-pull |
| l_wr_n | output | 1 | Left write strobe to the array, active low |
| r_cs_n | input | 1 | Right chip select, active low |
| r_addr | input | AW | Right address |
| r_we_n | input | 1 | Right write strobe from the port, active low |
| r_busy_in_n | input | 1 | Right busy level from the pin (used in slave mode) |
| r_busy_n | output | 1 | Right busy flag, active low, push-pull |
| r_wr_n | output | 1 | Right write strobe to the array, active low |
| busy_drive | output | 1 | Output enable for both busy pins |

## Verification
Busy, gated writes and `busy_drive` are combinational. They are due in the same cycle as the stimulus, so the bench drives inputs just after a falling edge and samples shortly before the next rising edge. The ages are the only registered state. A change driven after rising edge n gives an age of 0 until edge n+1, and an age of k after k more edges. The bench therefore logs the edge count at each real change of a port's select or address and derives the expected age from that log, saturated at the top value. This lets each sampled cycle be checked against the age-based rule without looking at internal state.

// File: rtl/port_clash_arbiter.sv
module port_clash_arbiter #(
  parameter int AW    = 16,
  parameter int AGE_W = 4,
  parameter int WIN   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slave_mode,
  input  logic          l_cs_n,
  input  logic [AW-1:0] l_addr,
  input  logic          l_we_n,
  input  logic          l_busy_in_n,
  output logic          l_busy_n,
  output logic          l_wr_n,
  input  logic          r_cs_n,
  input  logic [AW-1:0] r_addr,
  input  logic          r_we_n,
  input  logic          r_busy_in_n,
  output logic          r_busy_n,
  output logic          r_wr_n,
  output logic          busy_drive
);
  localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};
  localparam logic [AGE_W-1:0] AGE_ONE = AGE_W'(1);
  localparam logic [AW:0]      IDLE    = {1'b1, {AW{1'b0}}};

  logic [AW:0]      l_prev, r_prev;
  logic [AGE_W-1:0] l_age_q, r_age_q, l_age, r_age, gap;
  logic             l_chg, r_chg, clash, near, r_loses;
  logic             l_busy, r_busy, l_block, r_block;

  assign l_chg = {l_cs_n, l_addr} != l_prev;
  assign r_chg = {r_cs_n, r_addr} != r_prev;
  assign l_age = l_chg ? '0 : l_age_q;
  assign r_age = r_chg ? '0 : r_age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_prev  <= IDLE;
      r_prev  <= IDLE;
      l_age_q <= AGE_MAX;
      r_age_q <= AGE_MAX;
    end else begin
      l_prev  <= {l_cs_n, l_addr};
      r_prev  <= {r_cs_n, r_addr};
      l_age_q <= l_chg ? AGE_ONE : (l_age_q == AGE_MAX ? l_age_q : l_age_q + AGE_ONE);
      r_age_q <= r_chg ? AGE_ONE : (r_age_q == AGE_MAX ? r_age_q : r_age_q + AGE_ONE);
    end
  end

  assign clash   = !slave_mode && !l_cs_n && !r_cs_n && (l_addr == r_addr);
  assign gap     = (l_age > r_age) ? l_age - r_age : r_age - l_age;
  assign near    = int'(gap) < WIN;
  assign r_loses = near || (l_age > r_age);

  assign l_busy = clash && !r_loses;
  assign r_busy = clash && r_loses;

  assign l_busy_n   = !l_busy;
  assign r_busy_n   = !r_busy;
  assign busy_drive = !slave_mode;

  assign l_block = slave_mode ? !l_busy_in_n : l_busy;
  assign r_block = slave_mode ? !r_busy_in_n : r_busy;
  assign l_wr_n  = l_we_n || l_block;
  assign r_wr_n  = r_we_n || r_block;

  AST_NO_DUAL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !(!l_busy_n && !r_busy_n)); // R4
  AST_NOMATCH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (l_addr != r_addr) |-> (l_busy_n && r_busy_n)); // R1
  AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (l_cs_n || r_cs_n) |-> (l_busy_n && r_busy_n)); // R2
  AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    slave_mode |-> (l_busy_n && r_busy_n && !busy_drive)); // R7
  AST_LOSER_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave_mode && (!l_busy_n || !r_busy_n)) |-> ((!l_busy_n -> l_wr_n) && (!r_busy_n -> r_wr_n))); // R6
  AST_MASTER_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    !slave_mode |-> busy_drive); // R8
endmodule

// File: tb/port_clash_arbiter_test.sv
module port_clash_arbiter_test;
  localparam int AW = 4, AGE_W = 4, WIN = 2;
  localparam int SAT = (1 << AGE_W) - 1;

  logic clk = 0, rst_n = 0, slave_mode = 0;
  logic l_cs_n = 1, l_we_n = 1, l_busy_in_n = 1, r_cs_n = 1, r_we_n = 1, r_busy_in_n = 1;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic l_busy_n, l_wr_n, r_busy_n, r_wr_n, busy_drive;

  int cyc = 0, l_last = -1000, r_last = -1000, tests = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  port_clash_arbiter #(.AW(AW), .AGE_W(AGE_W), .WIN(WIN)) uut (
    .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode),
    .l_cs_n(l_cs_n), .l_addr(l_addr), .l_we_n(l_we_n), .l_busy_in_n(l_busy_in_n),
    .l_busy_n(l_busy_n), .l_wr_n(l_wr_n),
    .r_cs_n(r_cs_n), .r_addr(r_addr), .r_we_n(r_we_n), .r_busy_in_n(r_busy_in_n),
    .r_busy_n(r_busy_n), .r_wr_n(r_wr_n), .busy_drive(busy_drive));

  function automatic int age_of(int last);
    int a = cyc - last;
    return (a > SAT) ? SAT : a;
  endfunction

  task automatic chk(string tag, string what, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic set_l(logic cs, logic [AW-1:0] a);
    if ({cs, a} != {l_cs_n, l_addr}) l_last = cyc;
    l_cs_n = cs; l_addr = a;
  endtask

  task automatic set_r(logic cs, logic [AW-1:0] a);
    if ({cs, a} != {r_cs_n, r_addr}) r_last = cyc;
    r_cs_n = cs; r_addr = a;
  endtask

  task automatic verify();
    int la = age_of(l_last), ra = age_of(r_last);
    int d = (la > ra) ? la - ra : ra - la;
    bit en = !l_cs_n && !r_cs_n, m = (l_addr == r_addr);
    bit clash = !slave_mode && en && m;
    bit rlose = (d < WIN) || (la > ra);
    logic el = !(clash && !rlose), er = !(clash && rlose);
    string tag = slave_mode ? "R7" : (!en ? "R2" : (!m ? "R1" : (d < WIN ? "R4" : "R3")));
    string wt = slave_mode ? "R7" : "R6";
    chk(tag, "l_busy_n", l_busy_n, el);
    chk(tag, "r_busy_n", r_busy_n, er);
    chk(wt, "l_wr_n", l_wr_n, l_we_n | (slave_mode ? !l_busy_in_n : !el));
    chk(wt, "r_wr_n", r_wr_n, r_we_n | (slave_mode ? !r_busy_in_n : !er));
    chk("R8", "busy_drive", busy_drive, !slave_mode);
  endtask

  task automatic step();
    #2 verify();
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // reset state: idle, both free (R2, R8)
    step();
    // R4: simultaneous arrival, left wins
    set_l(0, 2); set_r(0, 2); l_we_n = 0; r_we_n = 0;
    repeat (3) step();
    // R9: release in same cycle
    set_l(1, 2); step();
    set_l(1, 0); set_r(1, 0); repeat (4) step();
    // R3: left early, right 5 later -> right busy
    set_l(0, 5); repeat (5) step();
    set_r(0, 5); repeat (3) step();
    set_l(1, 5); set_r(1, 5); step();
    // R3/R6: right early, left later -> left busy, left write blocked
    set_r(0, 7); repeat (6) step();
    set_l(0, 7); repeat (4) step();
    // R5: keep clashing until both ages saturate -> tie rule
    repeat (20) step();
    set_l(1, 0); set_r(1, 0); step();
    // R4: arrivals one cycle apart
    set_l(0, 3); step(); set_r(0, 3); repeat (3) step();
    // R7: slave mode, busy inputs gate writes
    slave_mode = 1; l_busy_in_n = 0; r_busy_in_n = 1; repeat (2) step();
    l_busy_in_n = 1; r_busy_in_n = 0; repeat (2) step();
    // R6: master mode ignores busy inputs
    slave_mode = 0; l_busy_in_n = 0; r_busy_in_n = 0; repeat (2) step();
    // R1: different addresses
    set_r(0, 4); repeat (2) step();
    // random phase
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(3) == 0) set_l($urandom_range(2) == 0, 4'($urandom_range(3)));
      if ($urandom_range(3) == 0) set_r($urandom_range(2) == 0, 4'($urandom_range(3)));
      l_we_n = 1'($urandom_range(1)); r_we_n = 1'($urandom_range(1));
      l_busy_in_n = 1'($urandom_range(1)); r_busy_in_n = 1'($urandom_range(1));
      if ($urandom_range(49) == 0) slave_mode = !slave_mode;
      step();
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule